// File: doc/BRIEF.md
# DMA Level-Sensitive Request Acceptor

This block turns an active-low, level-sensitive request pin into a controlled stream of single transfers for one DMA channel running in cycle-steal mode. The pin first passes through a synchronizer. Only while acceptance is open does the block look at the pin. When it sees a low level, it latches a pending request and pulses a start strobe to the transfer engine.

Acceptance then stays shut. The engine's activation strobe clears the pending request, and the pin is looked at again only after the engine reports that the single transfer cycle has ended. A pin held low therefore yields exactly one request per completed transfer cycle, and never a backlog of queued requests.

When the engine reports the last cycle, with the transfer count at zero, the channel stays closed until its enable is dropped and raised again. Dropping the enable at any time discards a pending request.

Top module: `dma_req_acceptor`

## Requirements
- R1: While reset is asserted and just after it is released, `pend_o` and `start_o` are 0.
- R2: The pin passes through two synchronizer flops. With acceptance open, a low level applied before clock edge n sets `pend_o` after edge n+2.
- R3: Once set, `pend_o` stays 1 while the channel is enabled and `act_i` is 0, even if the pin returns high.
- R4: `act_i` while `pend_o` is 1 clears `pend_o` after the next edge.
- R5: Between activation and the end of the cycle (`cyc_done_i`), the pin is ignored and `pend_o` stays 0.
- R6: `cyc_done_i` with `cnt_zero_i` = 0 reopens acceptance. A pin that is still low sets `pend_o` on the edge after the one that saw `cyc_done_i`.
- R7: `start_o` is a one-cycle pulse in the first cycle of each new pending request. A continuously low pin gives exactly one pulse per completed transfer cycle.
- R8: `cyc_done_i` with `cnt_zero_i` = 1 closes acceptance. `pend_o` stays 0 with the pin low until `chan_en_i` goes 0 and then 1 again, after which the request is accepted.
- R9: `chan_en_i` = 0 clears `pend_o` after the next edge and keeps acceptance closed while it is 0.
- R10: `act_i` and `cyc_done_i` have no effect while no request is pending and no cycle is in progress; a later low pin is accepted with normal timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_ni | input | 1 | Asynchronous active-low transfer request pin |
| chan_en_i | input | 1 | Channel enable |
| act_i | input | 1 | Engine activation strobe |
| cyc_done_i | input | 1 | End-of-single-cycle strobe |
| cnt_zero_i | input | 1 | Transfer count reached zero, qualified by `cyc_done_i` |
| pend_o | output | 1 | Request held, awaiting activation |
| start_o | output | 1 | One-cycle pulse on each new held request |

## Verification
The hardest case to reach is a pin that stays low through a whole transfer. In that case no fresh falling edge arrives, so only the closed acceptance window stops a second request from being queued during the busy period. The stimulus holds the pin low across a sweep of transfers with varying activation-to-completion gaps and checks that `pend_o` stays silent during each gap. It then checks that exactly one start pulse follows each completion, and that nothing follows the final one until the enable is cycled.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // channel disabled
    ST_OPEN = 3'd1,  // sampling the pin
    ST_HELD = 3'd2,  // request pending
    ST_BUSY = 3'd3,  // single cycle in progress
    ST_LAST = 3'd4   // count exhausted, wait for re-enable
  } acc_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic req_seen_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b1;
      else if (i == 0) stg_q[i] <= req_ni;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign req_seen_o = ~stg_q[STAGES-1];
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_seen_i,
  input  logic chan_en_i,
  input  logic act_i,
  input  logic cyc_done_i,
  input  logic cnt_zero_i,
  output logic pend_o
);
  acc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = ST_OPEN;
      ST_OPEN: if (req_seen_i) state_d = ST_HELD;
      ST_HELD: if (act_i) state_d = ST_BUSY;
      ST_BUSY: if (cyc_done_i) state_d = cnt_zero_i ? ST_LAST : ST_OPEN;
      ST_LAST: state_d = ST_LAST;
      default: state_d = ST_IDLE;
    endcase
    if (!chan_en_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  assign pend_o = (state_q == ST_HELD);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && chan_en_i && !act_i |=> pend_o);
  a_r4_act_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && act_i |=> !pend_o);
  a_r5_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_BUSY |=> !pend_o);
  a_r8_last_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LAST && chan_en_i |=> !pend_o);
  a_r9_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> !pend_o);
endmodule

// File: rtl/dma_req_pulse.sv
module dma_req_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else level_q <= level_i;
  end

  assign pulse_o = level_i & ~level_q;

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/dma_req_acceptor.sv
module dma_req_acceptor #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic chan_en_i,
  input  logic act_i,
  input  logic cyc_done_i,
  input  logic cnt_zero_i,
  output logic pend_o,
  output logic start_o
);
  logic req_seen;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_ni(req_ni), .req_seen_o(req_seen)
  );

  dma_req_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_seen_i(req_seen),
    .chan_en_i(chan_en_i), .act_i(act_i), .cyc_done_i(cyc_done_i),
    .cnt_zero_i(cnt_zero_i), .pend_o(pend_o)
  );

  dma_req_pulse u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(pend_o), .pulse_o(start_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i) $rose(rst_ni) |-> !pend_o && !start_o);
endmodule

// File: tb/dma_req_acceptor_bench.sv
`timescale 1ns/1ps
module dma_req_acceptor_bench;
  logic clk = 1'b0;
  logic rst_ni, req_ni, chan_en, act, cyc_done, cnt_zero;
  logic pend, start;
  int checks = 0, errors = 0, starts = 0, exp_starts = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_req_acceptor u_dma_req_acceptor (
    .clk_i(clk), .rst_ni(rst_ni), .req_ni(req_ni), .chan_en_i(chan_en),
    .act_i(act), .cyc_done_i(cyc_done), .cnt_zero_i(cnt_zero),
    .pend_o(pend), .start_o(start)
  );

  task automatic step();
    @(negedge clk);
    starts += int'(start);
  endtask

  task automatic chk(input string tag, input logic act_v, input logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  initial begin
    rst_ni = 0; req_ni = 1; chan_en = 0; act = 0; cyc_done = 0; cnt_zero = 0;
    step(); step();
    chk("R1 pend in reset", pend, 0);
    chk("R1 start in reset", start, 0);
    rst_ni = 1;
    step();
    chk("R1 pend after reset", pend, 0);
    chk("R1 start after reset", start, 0);

    // R10: stray strobes while idle/open
    chan_en = 1; step();
    act = 1; cyc_done = 1; cnt_zero = 1; step();
    act = 0; cyc_done = 0; cnt_zero = 0;
    chk("R10 stray strobes pend", pend, 0);

    // R2: latency through synchronizer
    req_ni = 0;
    step(); chk("R2 edge1 pend", pend, 0);
    step(); chk("R2 edge2 pend", pend, 0);
    step(); chk("R2 edge3 pend", pend, 1);
    chk("R7 start with new pend", start, 1); exp_starts++;
    chk("R10 accepted after stray strobes", pend, 1);
    step(); chk("R7 start one cycle", start, 0);
    req_ni = 1;
    for (int i = 0; i < 3; i++) begin step(); chk("R3 held with pin high", pend, 1); end

    act = 1; step(); act = 0;
    chk("R4 act clears pend", pend, 0);
    req_ni = 0;
    for (int i = 0; i < 4; i++) begin step(); chk("R5 busy ignores pin", pend, 0); end
    cyc_done = 1; step(); cyc_done = 0;
    chk("R6 no pend on done edge", pend, 0);
    step(); chk("R6 reopen pend", pend, 1); chk("R7 start after reopen", start, 1);
    exp_starts++;

    // sweep: pin held low across transfers with varying gaps
    for (int n = 0; n < 6; n++) begin
      for (int w = 0; w < n % 3; w++) begin step(); chk("R3 waiting act", pend, 1); end
      act = 1; step(); act = 0;
      chk("R4 act clears in sweep", pend, 0);
      for (int d = 0; d < (n % 4) + 1; d++) begin step(); chk("R5 sweep busy quiet", pend, 0); end
      cyc_done = 1; cnt_zero = (n == 5); step(); cyc_done = 0; cnt_zero = 0;
      step();
      if (n != 5) begin
        chk("R6 sweep reopen", pend, 1); chk("R7 sweep start", start, 1);
        exp_starts++;
      end else begin
        chk("R8 last closes", pend, 0);
      end
    end
    for (int i = 0; i < 4; i++) begin step(); chk("R8 closed until re-enable", pend, 0); end
    chk("R7 one start per cycle", (starts == exp_starts), 1);

    chan_en = 0; step(); chan_en = 1; step();
    chk("R8 reopen edge", pend, 0);
    step(); chk("R8 accepted after re-enable", pend, 1);

    chan_en = 0; step();
    chk("R9 disable drops pend", pend, 0);
    for (int i = 0; i < 3; i++) begin step(); chk("R9 closed while disabled", pend, 0); end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule